// File: doc/BRIEF.md
# Power-fail write-protect controller

This block supervises the path between a host memory bus and a battery-backed static RAM array. Two comparator flags arrive from analog circuitry outside the block. One says the supply has dropped under the deselect threshold. The other says it has dropped under the battery switchover threshold. Both flags are asynchronous. Each one is synchronised and debounced before the block uses it.

From the cleaned flags a five-state controller decides when the host's chip-select, write strobe and read data drive may reach the array. When the supply sags, an access already in progress may complete. Protection is still forced once a bounded write-protect window expires. Below the switchover threshold the controller steers a battery-select output. When the supply returns, protection stays on for a long recovery interval so that the host can settle. Each timer length is a parameter counted in clock cycles. With a 50 MHz clock the defaults give a write-protect window of 100 µs and a recovery time of 60 ms.

The analog comparators, the battery and the power switch itself are outside this block. Every output is registered. The gated strobes therefore follow the host inputs one clock later.

Top module: `pfwp_ctrl`

## Requirements
- R1: While reset is held and after it is released, wr_protect is 1, all three gated outputs are 0 and bat_select is 0. With no flag raised, wr_protect falls after exactly REC_CYC clock edges following release.
- R2: In normal operation, after each edge: mem_cs equals host_sel, mem_we equals host_sel AND host_wr, and mem_dq_oe equals host_sel AND host_rd AND NOT host_wr, using the inputs sampled at that edge. mem_dq_oe and mem_we are never 1 together.
- R3: Each flag passes through two flip-flops and must then hold a new level for FILT_LEN consecutive samples before it is accepted. The accepted level changes on edge 2+FILT_LEN after the raw input changes. A pulse that lasts fewer than FILT_LEN samples has no effect on any output.
- R4: If host_sel is 0 when the deselect flag is accepted, wr_protect rises on the next edge, edge 3+FILT_LEN after the raw change.
- R5: If host_sel is 1 when the deselect flag is accepted, the access continues with mem_cs held at 1. Protection engages on the first edge at which host_sel is sampled 0.
- R6: If the access is still running WP_CYC edges after it was allowed to continue, protection is forced on that edge.
- R7: While wr_protect is 1, mem_cs, mem_we and mem_dq_oe are 0 whatever host_sel, host_wr and host_rd do.
- R8: bat_select rises on the edge after the switchover flag is accepted and falls on the edge after its release is accepted. wr_protect stays 1 throughout.
- R9: After the deselect flag's release is accepted, protection stays on. wr_protect falls exactly REC_CYC edges after the edge at which recovery starts. Protection never ends except out of recovery.
- R10: If the deselect flag clears while an access is still being allowed to finish, the controller still protects, at the access end or at the deadline. It then stays protected through a full recovery before normal operation resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_below_dsel | input | 1 | Asynchronous flag: supply under deselect threshold |
| pf_below_swo | input | 1 | Asynchronous flag: supply under battery switchover threshold |
| host_sel | input | 1 | Host access request (chip select, active high) |
| host_wr | input | 1 | Host write request |
| host_rd | input | 1 | Host read / output enable request |
| mem_cs | output | 1 | Gated chip select to the array |
| mem_we | output | 1 | Gated write strobe to the array |
| mem_dq_oe | output | 1 | Data output drive enable; 0 means high impedance |
| wr_protect | output | 1 | Array is deselected and write protected |
| bat_select | output | 1 | 1 selects the backup battery, 0 the external supply |

## Verification
The bench builds the controller with FILT_LEN=3, WP_CYC=12 and REC_CYC=20. With these values every edge of the debounce, write-protect and recovery windows can be checked one by one in a short run. The bench sweeps the moment the host ends its access across the whole write-protect window, from before the flag is accepted to past the deadline. It also sweeps glitch widths up to the acceptance length, and every combination of the three host controls in both the open and the protected state. Expected edge numbers come from the latency formula of each requirement.

// File: rtl/pfwp_pkg.sv
package pfwp_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL    = 3'd0,
    ST_PENDING   = 3'd1,
    ST_PROTECTED = 3'd2,
    ST_BATTERY   = 3'd3,
    ST_RECOVERY  = 3'd4
  } pfwp_state_e;

  // Host strobes may reach the array only in these states.
  function automatic logic path_open(input pfwp_state_e st);
    return (st == ST_NORMAL) || (st == ST_PENDING);
  endfunction

endpackage

// File: rtl/pfwp_flag_filter.sv
module pfwp_flag_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic flt_out
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          s1_q, s2_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      flt_out <= 1'b0;
      run_q   <= '0;
    end else begin
      s1_q <= raw_in;
      s2_q <= s1_q;
      if (s2_q == flt_out) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        flt_out <= s2_q;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pfwp_timer.sv
module pfwp_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/pfwp_ctrl.sv
module pfwp_ctrl
  import pfwp_pkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int WP_CYC   = 5000,
  parameter int REC_CYC  = 3000000
) (
  input  logic clk,
  input  logic rst,
  input  logic pf_below_dsel,
  input  logic pf_below_swo,
  input  logic host_sel,
  input  logic host_wr,
  input  logic host_rd,
  output logic mem_cs,
  output logic mem_we,
  output logic mem_dq_oe,
  output logic wr_protect,
  output logic bat_select
);
  localparam int NFLAG = 2;
  localparam int MAXC  = (WP_CYC > REC_CYC) ? WP_CYC : REC_CYC;
  localparam int TW    = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [TW-1:0] WP_LOAD  = TW'(WP_CYC - 1);
  localparam logic [TW-1:0] REC_LOAD = TW'(REC_CYC - 1);

  logic [NFLAG-1:0] raw_flags, flt_flags;
  logic             dsel_low, swo_low;

  assign raw_flags = {pf_below_swo, pf_below_dsel};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    pfwp_flag_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst    (rst),
      .raw_in (raw_flags[i]),
      .flt_out(flt_flags[i])
    );
  end

  assign dsel_low = flt_flags[0];
  assign swo_low  = flt_flags[1];

  pfwp_state_e   state_q, state_n;
  logic          t_load_n, t_load, t_done;
  logic [TW-1:0] t_val_n, t_val;

  assign t_load = rst | t_load_n;
  assign t_val  = rst ? REC_LOAD : t_val_n;

  pfwp_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .load    (t_load),
    .load_val(t_val),
    .done    (t_done)
  );

  always_comb begin
    state_n  = state_q;
    t_load_n = 1'b0;
    t_val_n  = '0;
    unique case (state_q)
      ST_NORMAL: begin
        if (swo_low) begin
          state_n = ST_BATTERY;
        end else if (dsel_low) begin
          if (host_sel) begin
            state_n  = ST_PENDING;
            t_load_n = 1'b1;
            t_val_n  = WP_LOAD;
          end else begin
            state_n = ST_PROTECTED;
          end
        end
      end
      ST_PENDING: begin
        if (swo_low) begin
          state_n = ST_BATTERY;
        end else if (!host_sel || t_done) begin
          state_n = ST_PROTECTED;
        end
      end
      ST_PROTECTED: begin
        if (swo_low) begin
          state_n = ST_BATTERY;
        end else if (!dsel_low) begin
          state_n  = ST_RECOVERY;
          t_load_n = 1'b1;
          t_val_n  = REC_LOAD;
        end
      end
      ST_BATTERY: begin
        if (!swo_low) begin
          state_n = ST_PROTECTED;
        end
      end
      ST_RECOVERY: begin
        if (swo_low) begin
          state_n = ST_BATTERY;
        end else if (dsel_low) begin
          state_n = ST_PROTECTED;
        end else if (t_done) begin
          state_n = ST_NORMAL;
        end
      end
      default: state_n = ST_RECOVERY;
    endcase
  end

  logic open_n;
  assign open_n = path_open(state_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_RECOVERY;
      mem_cs     <= 1'b0;
      mem_we     <= 1'b0;
      mem_dq_oe  <= 1'b0;
      wr_protect <= 1'b1;
      bat_select <= 1'b0;
    end else begin
      state_q    <= state_n;
      mem_cs     <= open_n & host_sel;
      mem_we     <= open_n & host_sel & host_wr;
      mem_dq_oe  <= open_n & host_sel & host_rd & ~host_wr;
      wr_protect <= ~open_n;
      bat_select <= (state_n == ST_BATTERY);
    end
  end
endmodule

// File: rtl/pfwp_ctrl_chk.sv
module pfwp_ctrl_chk
  import pfwp_pkg::*;
#(
  parameter int WP_CYC = 5000
) (
  input logic        clk,
  input logic        rst,
  input logic        mem_cs,
  input logic        mem_we,
  input logic        mem_dq_oe,
  input logic        wr_protect,
  input logic        bat_select,
  input pfwp_state_e state_q
);
  logic [31:0] pend_run;

  always_ff @(posedge clk) begin
    if (rst)                         pend_run <= '0;
    else if (state_q == ST_PENDING)  pend_run <= pend_run + 1'b1;
    else                             pend_run <= '0;
  end

  AST_PROT_GATES: assert property (@(posedge clk) disable iff (rst)
    wr_protect |-> (!mem_cs && !mem_we && !mem_dq_oe)); // R7
  AST_BAT_PROT: assert property (@(posedge clk) disable iff (rst)
    bat_select |-> wr_protect); // R8
  AST_DQ_NOT_WR: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> !mem_we); // R2
  AST_WP_DEADLINE: assert property (@(posedge clk) disable iff (rst)
    pend_run <= 32'(WP_CYC)); // R6
  AST_PEND_HOLDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PENDING) |-> mem_cs); // R5
  AST_EXIT_VIA_REC: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_protect) |-> ($past(state_q) == ST_RECOVERY)); // R9
endmodule

bind pfwp_ctrl pfwp_ctrl_chk #(.WP_CYC(WP_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_cs    (mem_cs),
  .mem_we    (mem_we),
  .mem_dq_oe (mem_dq_oe),
  .wr_protect(wr_protect),
  .bat_select(bat_select),
  .state_q   (state_q)
);

// File: tb/pfwp_ctrl_test.sv
`timescale 1ns/1ps
module pfwp_ctrl_test;
  localparam int F   = 3;
  localparam int WP  = 12;
  localparam int REC = 20;
  localparam int D   = 3 + F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dsel_raw = 1'b0, swo_raw = 1'b0;
  logic sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic mem_cs, mem_we, mem_dq_oe, wr_protect, bat_select;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pfwp_ctrl #(.FILT_LEN(F), .WP_CYC(WP), .REC_CYC(REC)) uut (
    .clk(clk), .rst(rst), .pf_below_dsel(dsel_raw), .pf_below_swo(swo_raw),
    .host_sel(sel), .host_wr(wr), .host_rd(rd),
    .mem_cs(mem_cs), .mem_we(mem_we), .mem_dq_oe(mem_dq_oe),
    .wr_protect(wr_protect), .bat_select(bat_select)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_recovery();
    dsel_raw = 1'b0; swo_raw = 1'b0; sel = 1'b0; wr = 1'b0; rd = 1'b0;
    for (int k = 1; k <= D + REC + 1; k++) step();
    check("R9 settled", wr_protect, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state and recovery length
    repeat (3) step();
    check("R1 wprot", wr_protect, 1'b1);
    check("R1 cs", mem_cs, 1'b0);
    check("R1 bat", bat_select, 1'b0);
    rst = 1'b0; sel = 1'b1;
    for (int k = 1; k <= REC + 1; k++) begin
      step();
      check("R1 wprot", wr_protect, k < REC);
      check("R1 cs", mem_cs, !(k < REC));
    end

    // R2: all host control combinations in normal operation
    for (int c = 0; c < 8; c++) begin
      sel = c[0]; wr = c[1]; rd = c[2];
      step();
      check("R2 cs", mem_cs, c[0]);
      check("R2 we", mem_we, c[0] & c[1]);
      check("R2 oe", mem_dq_oe, c[0] & c[2] & ~c[1]);
    end
    sel = 1'b0; wr = 1'b0; rd = 1'b0;

    // R3: short pulses are ignored
    for (int w = 1; w < F; w++) begin
      dsel_raw = 1'b1;
      for (int k = 0; k < w; k++) step();
      dsel_raw = 1'b0;
      sel = 1'b1;
      for (int k = 0; k < D + 3; k++) begin
        step();
        check("R3 glitch wprot", wr_protect, 1'b0);
        check("R3 glitch cs", mem_cs, 1'b1);
      end
      sel = 1'b0;
      step();
    end
    // R3: pulse of exactly F samples is accepted
    dsel_raw = 1'b1;
    for (int k = 1; k <= F; k++) step();
    dsel_raw = 1'b0;
    for (int k = F + 1; k <= D; k++) begin
      step();
      check("R3 accept", wr_protect, k >= D);
    end
    wait_recovery();

    // R4 idle deselect, R7 ignore inputs, R9 recovery
    dsel_raw = 1'b1;
    for (int k = 1; k <= D + 1; k++) begin
      step();
      check("R4 wprot", wr_protect, k >= D);
    end
    for (int c = 0; c < 8; c++) begin
      sel = c[0]; wr = c[1]; rd = c[2];
      step();
      check("R7 cs", mem_cs, 1'b0);
      check("R7 we", mem_we, 1'b0);
      check("R7 oe", mem_dq_oe, 1'b0);
    end
    sel = 1'b0; wr = 1'b0; rd = 1'b0;
    dsel_raw = 1'b0;
    for (int k = 1; k <= D + REC + 1; k++) begin
      step();
      check("R9 hold", wr_protect, k < D + REC);
    end

    // R5 / R6: sweep the access end across the window
    for (int j = 0; j <= D + WP + 1; j++) begin
      int r;
      r = j + 1;
      if (r > D + WP) r = D + WP;
      if (r < D) r = D;
      sel = (j > 0); rd = 1'b1; dsel_raw = 1'b1;
      for (int k = 1; k <= D + WP + 2; k++) begin
        step();
        check((r == D + WP) ? "R6 deadline" : "R5 finish", wr_protect, k >= r);
        check("R5 cs", mem_cs, (k < r) && (k <= j));
        if (k == j) sel = 1'b0;
      end
      wait_recovery();
    end

    // R10: supply returns while the access is still allowed to finish
    sel = 1'b1; dsel_raw = 1'b1;
    for (int k = 1; k <= D + WP + REC + 2; k++) begin
      step();
      check("R10 wprot", wr_protect, (k >= D + WP) && (k < D + WP + 1 + REC));
      if (k == D) dsel_raw = 1'b0;
    end
    sel = 1'b0;

    // R8: battery switchover
    dsel_raw = 1'b1;
    for (int k = 0; k <= D; k++) step();
    swo_raw = 1'b1;
    for (int k = 1; k <= D + 1; k++) begin
      step();
      check("R8 bat on", bat_select, k >= D);
      check("R8 wprot", wr_protect, 1'b1);
    end
    sel = 1'b1; wr = 1'b1;
    step();
    check("R7 battery we", mem_we, 1'b0);
    sel = 1'b0; wr = 1'b0;
    swo_raw = 1'b0;
    for (int k = 1; k <= D + 1; k++) begin
      step();
      check("R8 bat off", bat_select, k < D);
      check("R8 wprot", wr_protect, 1'b1);
    end
    wait_recovery();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule